// File: doc/BRIEF.md
# Reloading Down-Counter Pulse Generator

This block is one channel of a 16-bit timer that emits an endless train of toggling pulses. Software first loads a start count and a reload value. It then starts the channel, either by writing the enable bit or through an external start input. While the channel runs, the counter steps down by one on every count tick. Each time it passes zero it signals an underflow, inverts the output flip-flop, and raises one-clock interrupt and DMA request pulses. On the tick after that, it refills itself from the reload value.

The counter reads back as all-ones during the underflow count. On the next tick it holds the reload value minus one. The first period is therefore the start count plus one ticks, and every later period is the reload value plus one ticks. The output also inverts on the first tick after the channel starts, so the waveform can begin without a separate preset. Only a software write of zero to the enable bit stops the channel. While it is stopped, the counter and the output hold their values.

Top module: `pulse_timer_ch`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and reload register clear to 0, the channel stops, `pulse_out` goes low and both request outputs go low.
- R2: A `cnt_wr` strobe puts `wdata` on `count` after that clock edge, whether the channel runs or not, and the write overrides a tick in the same cycle. A `rld_wr` strobe stores `wdata` for later reloads and leaves the count that is already running alone.
- R3: While the channel runs, each `tick` lowers `count` by 1. While the channel is stopped, ticks change neither `count` nor `pulse_out`.
- R4: A tick while `count` is 0 sets `count` to 16'hFFFF and marks an underflow. The next tick loads the reload value minus 1.
- R5: The first underflow comes on the (start count + 1)-th tick after the channel starts. Each later underflow comes (reload value + 1) ticks after the previous one.
- R6: `pulse_out` inverts on the first tick after the channel starts and on every underflow tick. Starting the channel does not change `pulse_out` before that first tick.
- R7: `irq_req` and `dma_req` are high together for exactly one clock, the clock that follows the edge of the underflow tick.
- R8: A write of 1 to the enable bit (`en_wr` with `en_val`=1) or an `ext_start` pulse starts the channel. Only a write of 0 stops it. If a write of 0 and `ext_start` come in the same cycle, the channel stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-clock enable, one system clock wide |
| cnt_wr | input | 1 | Write strobe for the counter |
| rld_wr | input | 1 | Write strobe for the reload register |
| wdata | input | W | Write data for either register |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| ext_start | input | 1 | External start request |
| count | output | W | Current counter value |
| pulse_out | output | 1 | Output flip-flop level |
| irq_req | output | 1 | Underflow interrupt request pulse |
| dma_req | output | 1 | Underflow DMA request pulse |
| running | output | 1 | Channel enable state |

## Verification
The assertions assume that `tick`, the write strobes and `ext_start` are sampled synchronously to `clk`. They also assume that a counter write has no tick of its own that software expects to count. The request-pulse checks further assume that two underflows can never fall on adjacent clocks. This holds because a reload tick always sits between them. The stimulus drives every input at the falling edge for exactly one clock. It uses start and reload values of at least 1, so the start toggle and an underflow never land on the same tick, and the expected underflow tick numbers in the scoreboard follow only from the programmed values.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_WRITE  = 3'd1,
    ACT_DEC    = 3'd2,
    ACT_UNDER  = 3'd3,
    ACT_RELOAD = 3'd4
  } cnt_act_e;
endpackage

// File: rtl/timer_en_ctl.sv
module timer_en_ctl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en_wr,
  input  logic en_val,
  input  logic ext_start,
  output logic en_q,
  output logic adv,
  output logic first_adv
);
  logic en_d;
  logic start_pend_q;

  // a software write always decides; external start can only set
  always_comb begin
    if (en_wr)          en_d = en_val;
    else if (ext_start) en_d = 1'b1;
    else                en_d = en_q;
  end

  assign adv       = en_q & tick;
  assign first_adv = adv & start_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= 1'b0;
      start_pend_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (!en_q && en_d)  start_pend_q <= 1'b1;
      else if (!en_d)     start_pend_q <= 1'b0;
      else if (adv)       start_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/timer_cnt_core.sv
module timer_cnt_core
  import timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         cnt_wr,
  input  logic         rld_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic         uf
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] rld_q;
  logic         rl_pend_q;
  cnt_act_e     act;

  always_comb begin
    if (cnt_wr)                     act = ACT_WRITE;
    else if (!adv)                  act = ACT_HOLD;
    else if (rl_pend_q)             act = ACT_RELOAD;
    else if (cnt_q == '0)           act = ACT_UNDER;
    else                            act = ACT_DEC;
  end

  assign uf = (act == ACT_UNDER);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      rl_pend_q <= 1'b0;
    end else begin
      if (rld_wr) rld_q <= wdata;
      unique case (act)
        ACT_WRITE: begin
          cnt_q     <= wdata;
          rl_pend_q <= 1'b0;
        end
        ACT_RELOAD: begin
          cnt_q     <= rld_q - ONE;
          rl_pend_q <= 1'b0;
        end
        ACT_UNDER: begin
          cnt_q     <= ALL_ONES;
          rl_pend_q <= 1'b1;
        end
        ACT_DEC:  cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/timer_out_stage.sv
module timer_out_stage #(
  parameter bit HAS_DMA = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic first_adv,
  input  logic uf,
  output logic pulse_q,
  output logic irq_q,
  output logic dma_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_q ^ first_adv ^ uf;
      irq_q   <= uf;
    end
  end

  generate
    if (HAS_DMA) begin : g_dma
      logic dma_r;
      always_ff @(posedge clk) begin
        if (rst) dma_r <= 1'b0;
        else     dma_r <= uf;
      end
      assign dma_q = dma_r;
    end else begin : g_no_dma
      assign dma_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pulse_timer_ch.sv
module pulse_timer_ch #(
  parameter int W       = 16,
  parameter bit HAS_DMA = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic         rld_wr,
  input  logic [W-1:0] wdata,
  input  logic         en_wr,
  input  logic         en_val,
  input  logic         ext_start,
  output logic [W-1:0] count,
  output logic         pulse_out,
  output logic         irq_req,
  output logic         dma_req,
  output logic         running
);
  logic adv;
  logic first_adv;
  logic uf;

  timer_en_ctl u_en (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .ext_start (ext_start),
    .en_q      (running),
    .adv       (adv),
    .first_adv (first_adv)
  );

  timer_cnt_core #(.W(W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .cnt_wr (cnt_wr),
    .rld_wr (rld_wr),
    .wdata  (wdata),
    .cnt_q  (count),
    .uf     (uf)
  );

  timer_out_stage #(.HAS_DMA(HAS_DMA)) u_out (
    .clk       (clk),
    .rst       (rst),
    .first_adv (first_adv),
    .uf        (uf),
    .pulse_q   (pulse_out),
    .irq_q     (irq_req),
    .dma_q     (dma_req)
  );
endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_wr,
  input logic [W-1:0] wdata,
  input logic         en_wr,
  input logic         en_val,
  input logic         ext_start,
  input logic [W-1:0] count,
  input logic         pulse_out,
  input logic         irq_req,
  input logic         dma_req,
  input logic         running
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !running && !pulse_out && !irq_req));

  assert_cnt_write_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(wdata)));

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!running && !cnt_wr) |=> $stable(count));

  assert_under_ones_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (count == {W{1'b1}}));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(pulse_out));

  assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  assert_req_pair_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> dma_req);

  assert_disable_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_val) |=> !running);

  assert_ext_start_R8: assert property (@(posedge clk) disable iff (rst)
    (ext_start && !en_wr) |=> running);
endmodule

bind pulse_timer_ch pulse_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_wr    (cnt_wr),
  .wdata     (wdata),
  .en_wr     (en_wr),
  .en_val    (en_val),
  .ext_start (ext_start),
  .count     (count),
  .pulse_out (pulse_out),
  .irq_req   (irq_req),
  .dma_req   (dma_req),
  .running   (running)
);

// File: tb/tb_pulse_timer_ch.sv
`timescale 1ns/1ps
module tb_pulse_timer_ch;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         cnt_wr = 1'b0;
  logic         rld_wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         en_wr = 1'b0;
  logic         en_val = 1'b0;
  logic         ext_start = 1'b0;
  logic [W-1:0] count;
  logic         pulse_out;
  logic         irq_req;
  logic         dma_req;
  logic         running;

  int checks = 0;
  int errors = 0;
  int ticks_sent = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pulse_timer_ch #(.W(W), .HAS_DMA(1'b1)) dut (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .rld_wr(rld_wr),
    .wdata(wdata), .en_wr(en_wr), .en_val(en_val), .ext_start(ext_start),
    .count(count), .pulse_out(pulse_out), .irq_req(irq_req),
    .dma_req(dma_req), .running(running)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    ticks_sent++;
  endtask

  task automatic write_cnt(input int v);
    @(negedge clk) begin cnt_wr = 1'b1; wdata = W'(v); end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic write_rld(input int v);
    @(negedge clk) begin rld_wr = 1'b1; wdata = W'(v); end
    @(negedge clk) rld_wr = 1'b0;
  endtask

  task automatic write_en(input bit v, input bit ext);
    @(negedge clk) begin en_wr = 1'b1; en_val = v; ext_start = ext; end
    @(negedge clk) begin en_wr = 1'b0; ext_start = 1'b0; end
  endtask

  // monitor: every request pulse must match the next predicted tick index (R5, R7)
  always @(negedge clk) begin
    #1;
    if (!rst && irq_req) begin
      check(dma_req == 1'b1, "R7 dma with irq", int'(dma_req), 1);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected underflow", ticks_sent, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(ticks_sent == e, "R5 underflow tick", ticks_sent, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    int pre;
    repeat (3) @(negedge clk);
    #1;
    check(count == 0 && !running && !pulse_out && !irq_req && !dma_req,
          "R1 reset state", int'(count), 0);
    @(negedge clk) rst = 1'b0;

    write_rld(3);
    write_cnt(5);
    check(count == 5, "R2 counter write", int'(count), 5);

    do_tick();
    check(count == 5, "R3 tick ignored while stopped", int'(count), 5);
    check(pulse_out == 1'b0, "R3 output kept while stopped", int'(pulse_out), 0);

    write_en(1'b1, 1'b0);
    check(running == 1'b1, "R8 software start", int'(running), 1);
    check(pulse_out == 1'b0, "R6 no toggle before first tick", int'(pulse_out), 0);

    base = ticks_sent;
    exp_q.push_back(base + 6);
    exp_q.push_back(base + 10);
    exp_q.push_back(base + 17);

    do_tick();
    check(pulse_out == 1'b1, "R6 start toggle", int'(pulse_out), 1);
    check(count == 4, "R3 decrement", int'(count), 4);
    repeat (4) do_tick();
    check(count == 0, "R3 reaches zero", int'(count), 0);
    do_tick();
    check(count == 16'hFFFF, "R4 all-ones on underflow", int'(count), 65535);
    check(irq_req == 1'b1, "R7 irq on underflow", int'(irq_req), 1);
    check(pulse_out == 1'b0, "R6 underflow toggle", int'(pulse_out), 0);
    @(negedge clk) #1;
    check(irq_req == 1'b0, "R7 irq one clock", int'(irq_req), 0);
    do_tick();
    check(count == 2, "R4 reload minus one", int'(count), 2);

    write_rld(6);
    check(count == 2, "R2 reload write leaves count", int'(count), 2);
    repeat (3) do_tick();
    check(pulse_out == 1'b1, "R6 second underflow toggle", int'(pulse_out), 1);
    do_tick();
    check(count == 5, "R2 new reload used next", int'(count), 5);
    repeat (6) do_tick();
    check(pulse_out == 1'b0, "R6 third underflow toggle", int'(pulse_out), 0);

    write_en(1'b0, 1'b0);
    check(running == 1'b0, "R8 software stop", int'(running), 0);
    pre = int'(count);
    repeat (3) do_tick();
    check(int'(count) == pre, "R3 count held when stopped", int'(count), pre);
    check(pulse_out == 1'b0, "R3 output held when stopped", int'(pulse_out), 0);

    write_en(1'b0, 1'b1);
    check(running == 1'b0, "R8 disable wins over external", int'(running), 0);

    @(negedge clk) ext_start = 1'b1;
    @(negedge clk) ext_start = 1'b0;
    #1;
    check(running == 1'b1, "R8 external start", int'(running), 1);
    exp_q.push_back(ticks_sent + 7);
    do_tick();
    check(pulse_out == 1'b1, "R6 start toggle after external start", int'(pulse_out), 1);
    check(count == 5, "R4 pending reload after restart", int'(count), 5);
    repeat (6) do_tick();

    @(negedge clk) begin cnt_wr = 1'b1; wdata = 16'd9; tick = 1'b1; end
    @(negedge clk) begin cnt_wr = 1'b0; tick = 1'b0; end
    check(count == 9, "R2 write beats tick", int'(count), 9);
    exp_q.push_back(ticks_sent + 10);
    repeat (10) do_tick();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all predicted underflows seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule